// File: doc/BRIEF.md
# Overcurrent Hiccup Protection Controller

This block decides when a two-channel switching converter must be shut down because of overcurrent, and how it tries to start again. Each channel supplies a flag that is high while its sensed current is above the limit. The block trips in two ways:

- at once, in any clock cycle in which every channel flag is high;
- when a single channel is seen above the limit on a fixed number of consecutive switching-cycle ticks.

After a trip it forces both the high-side and the low-side switch of every channel off, through one drive-disable output. It then counts a programmable number of switching cycles and requests a soft-start. A failed soft-start, or a new trip during the soft-start, sends it back to the wait. This retry loop repeats for as long as the block is enabled. A successful soft-start returns it to normal monitoring.

The controller has four states:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | Disabled, drives off |
| `ST_RUN` | Normal monitoring |
| `ST_WAIT` | Hiccup wait with drives off |
| `ST_SOFT` | Soft-start attempt in progress |

Its transitions are:

| From | To | Condition |
|------|----|-----------|
| `ST_IDLE` | `ST_RUN` | enable high |
| `ST_RUN` | `ST_WAIT` | trip |
| `ST_WAIT` | `ST_SOFT` | wait count complete |
| `ST_SOFT` | `ST_RUN` | soft-start done |
| `ST_SOFT` | `ST_WAIT` | soft-start fail or trip |
| any other state | `ST_IDLE` | enable low |

Threshold comparison and the soft-start ramp itself lie outside the block.

Top module: `ocp_hiccup_ctrl`

## Requirements
In these requirements the three outputs are written as one triple {drv_off, ss_req, fault}. The encodings are IDLE = 100, RUN = 000, WAIT = 101 and SOFT = 011. Every output changes on the first clock edge after the input that causes it.
- R1: While reset is asserted, and on the first cycle after it is released with enable low, the outputs are 100.
- R2: Enable high in IDLE moves the outputs to 000 after one edge.
- R3: In RUN or SOFT, a cycle in which all channel flags are high gives 101 after one edge, whether or not a cycle tick is present. A single channel flag that is high without a tick trips nothing.
- R4: A channel flag that is high on PERSIST_CYC (default 7) consecutive ticks trips on the last of them. One tick fewer does not trip.
- R5: A tick with a channel's flag low clears that channel's count. Flag values between ticks are not sampled.
- R6: After a trip the outputs stay 101 until WAIT_CYC ticks (default 4096) have occurred. The WAIT_CYC-th tick gives 011.
- R7: In SOFT, ss_done with ss_fail low and no trip gives 000.
- R8: In SOFT, ss_fail gives 101 and starts a fresh wait. It takes priority over ss_done, and the loop repeats indefinitely.
- R9: A trip by either criterion during SOFT counts as a soft-start failure and gives 101.
- R10: Enable low gives 100 after one edge from any state and clears all counts. After re-enabling, a channel needs a full run of PERSIST_CYC ticks to trip.
- R11: The per-channel counts are cleared on entering WAIT. A channel in SOFT therefore needs PERSIST_CYC fresh ticks to trip.
- R12: fault is high from the trip until a successful soft-start or a disable. drv_off and ss_req are never both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable |
| cyc_tick | input | 1 | One-clock pulse per switching cycle |
| oc_flags | input | NUM_CH | Per-channel over-limit flags |
| ss_done | input | 1 | Soft-start completed successfully |
| ss_fail | input | 1 | Soft-start failed |
| drv_off | output | 1 | Forces all switches of all channels off |
| ss_req | output | 1 | Soft-start request |
| fault | output | 1 | Overcurrent fault indicator |

## Verification
Every result of this block is due exactly one clock edge after the cycle that causes it:

- a dual trip, the last persistence tick, the last wait tick, a soft-start result, or a disable all change the outputs on the next edge;
- nothing is pipelined further.

The bench changes inputs on the falling edge and compares the output triple on the following falling edge, so each check reads the state that the single rising edge in between produced.

The sweeps cover tick runs from 1 to 8 on each channel and wait phases with tick spacings of 1 to 3 cycles. The expected trip tick and soft-start tick are worked out from the loop counters.

// File: rtl/ocp_hiccup_pkg.sv
package ocp_hiccup_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2,
        ST_SOFT = 2'd3
    } ocp_state_e;
endpackage

// File: rtl/ocp_persist_cnt.sv
module ocp_persist_cnt #(
    parameter int PERSIST_CYC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic active,
    input  logic tick,
    input  logic flag,
    output logic hit
);
    localparam int CW = (PERSIST_CYC > 1) ? $clog2(PERSIST_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERSIST_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign hit = active && tick && flag && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (active && tick) begin
            if (!flag) begin
                cnt_q <= '0;
            end else if (cnt_q != LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4
    persist_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R5
    persist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && !flag && !clr) |=> (cnt_q == '0));
endmodule

// File: rtl/ocp_wait_timer.sv
module ocp_wait_timer #(
    parameter int WAIT_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int TW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(WAIT_CYC - 1);

    logic [TW-1:0] cnt_q;

    assign done = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || done) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R6
    wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/ocp_trip_eval.sv
module ocp_trip_eval #(
    parameter int NUM_CH = 2
) (
    input  logic              active,
    input  logic [NUM_CH-1:0] flags,
    input  logic [NUM_CH-1:0] hits,
    output logic              trip
);
    logic all_hi;
    logic any_hit;

    always_comb begin
        all_hi  = &flags;
        any_hit = |hits;
        trip    = active && (all_hi || any_hit);
    end
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl
    import ocp_hiccup_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int PERSIST_CYC = 7,
    parameter int WAIT_CYC    = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cyc_tick,
    input  logic [NUM_CH-1:0] oc_flags,
    input  logic              ss_done,
    input  logic              ss_fail,
    output logic              drv_off,
    output logic              ss_req,
    output logic              fault
);
    ocp_state_e        state_q;
    ocp_state_e        state_n;
    logic              monitor;
    logic              trip;
    logic              wait_done;
    logic              cnt_clr;
    logic [NUM_CH-1:0] hits;

    assign monitor = (state_q == ST_RUN) || (state_q == ST_SOFT);
    assign cnt_clr = !monitor || (state_n != state_q);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ocp_persist_cnt #(.PERSIST_CYC(PERSIST_CYC)) u_persist (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (cnt_clr),
            .active (monitor),
            .tick   (cyc_tick),
            .flag   (oc_flags[c]),
            .hit    (hits[c])
        );
    end

    ocp_trip_eval #(.NUM_CH(NUM_CH)) u_trip (
        .active (monitor),
        .flags  (oc_flags),
        .hits   (hits),
        .trip   (trip)
    );

    ocp_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_WAIT),
        .tick  (cyc_tick),
        .done  (wait_done)
    );

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (en) state_n = ST_RUN;
            ST_RUN: begin
                if (!en)       state_n = ST_IDLE;
                else if (trip) state_n = ST_WAIT;
            end
            ST_WAIT: begin
                if (!en)            state_n = ST_IDLE;
                else if (wait_done) state_n = ST_SOFT;
            end
            ST_SOFT: begin
                if (!en)                  state_n = ST_IDLE;
                else if (trip || ss_fail) state_n = ST_WAIT;
                else if (ss_done)         state_n = ST_RUN;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        drv_off = 1'b1;
        ss_req  = 1'b0;
        fault   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin drv_off = 1'b1; ss_req = 1'b0; fault = 1'b0; end
            ST_RUN:  begin drv_off = 1'b0; ss_req = 1'b0; fault = 1'b0; end
            ST_WAIT: begin drv_off = 1'b1; ss_req = 1'b0; fault = 1'b1; end
            ST_SOFT: begin drv_off = 1'b0; ss_req = 1'b1; fault = 1'b1; end
            default: begin drv_off = 1'b1; ss_req = 1'b0; fault = 1'b0; end
        endcase
    end

    // R3
    dual_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (monitor && en && (&oc_flags)) |=> (drv_off && fault && !ss_req));

    // R8
    fail_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOFT && en && ss_fail) |=> (state_q == ST_WAIT));

    // R10
    disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (drv_off && !fault && !ss_req));

    // R12
    fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> (!$past(en) || ($past(ss_req) && $past(ss_done))));

    // R12
    exclusive_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_off && ss_req));
endmodule

// File: tb/ocp_hiccup_ctrl_bench.sv
module ocp_hiccup_ctrl_bench;
    localparam int NCH  = 2;
    localparam int PERS = 7;
    localparam int WCYC = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en = 1'b0;
    logic           cyc_tick = 1'b0;
    logic [NCH-1:0] oc_flags = '0;
    logic           ss_done = 1'b0;
    logic           ss_fail = 1'b0;
    logic           drv_off, ss_req, fault;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ocp_hiccup_ctrl #(.NUM_CH(NCH), .PERSIST_CYC(PERS), .WAIT_CYC(WCYC)) u_ocp_hiccup_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .cyc_tick(cyc_tick),
        .oc_flags(oc_flags), .ss_done(ss_done), .ss_fail(ss_fail),
        .drv_off(drv_off), .ss_req(ss_req), .fault(fault)
    );

    task automatic chk(input string req, input logic [2:0] exp);
        checks++;
        if ({drv_off, ss_req, fault} !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req,
                     {drv_off, ss_req, fault}, exp, $time);
        end
    endtask

    task automatic step(input logic t, input logic [NCH-1:0] f);
        cyc_tick = t;
        oc_flags = f;
        @(negedge clk);
        cyc_tick = 1'b0;
        oc_flags = '0;
        ss_done  = 1'b0;
        ss_fail  = 1'b0;
    endtask

    task automatic wait_phase(input int sp, input string req);
        for (int k = 1; k <= WCYC; k++) begin
            for (int j = 1; j < sp; j++) begin
                step(1'b0, '0);
                chk(req, 3'b101);
            end
            step(1'b1, '0);
            chk(req, (k < WCYC) ? 3'b101 : 3'b011);
        end
    endtask

    task automatic recover();
        wait_phase(1, "R6");
        ss_done = 1'b1;
        step(1'b0, '0);
        chk("R7", 3'b000);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk("R1", 3'b100);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, '0);
        chk("R1", 3'b100);
        en = 1'b1;
        step(1'b0, '0);
        chk("R2", 3'b000);

        // R4 R5: persistence sweep per channel, gaps between ticks with flag low
        for (int ch = 0; ch < NCH; ch++) begin
            for (int n = 1; n <= 8; n++) begin
                logic [NCH-1:0] m;
                m = '0;
                m[ch] = 1'b1;
                step(1'b1, '0);
                chk("R5", 3'b000);
                for (int i = 1; i <= n; i++) begin
                    if (i % 2 == 0) begin
                        step(1'b0, '0);
                        chk("R5", 3'b000);
                    end
                    step(1'b1, m);
                    if (i < PERS) begin
                        chk("R4", 3'b000);
                    end else begin
                        chk("R4", 3'b101);
                        break;
                    end
                end
                if (n >= PERS) recover();
            end
        end

        // R3: single flag without tick, then all flags
        step(1'b0, 2'b01);
        chk("R3", 3'b000);
        step(1'b0, 2'b11);
        chk("R3", 3'b101);

        // R6 R8 R7 R12: wait spacing sweep with fail then success
        for (int sp = 1; sp <= 3; sp++) begin
            wait_phase(sp, "R6");
            ss_fail = 1'b1;
            ss_done = 1'b1;
            step(1'b0, '0);
            chk("R8", 3'b101);
            wait_phase(sp, "R12");
            ss_done = 1'b1;
            step(1'b0, '0);
            chk("R7", 3'b000);
            step(1'b0, 2'b11);
            chk("R3", 3'b101);
        end

        // R9: dual trip during soft-start
        wait_phase(1, "R6");
        step(1'b0, 2'b11);
        chk("R9", 3'b101);

        // R11: count from before a trip does not carry into soft-start
        recover();
        for (int i = 1; i <= 5; i++) begin
            step(1'b1, 2'b01);
            chk("R11", 3'b000);
        end
        step(1'b0, 2'b11);
        chk("R11", 3'b101);
        wait_phase(1, "R6");
        for (int i = 1; i <= PERS; i++) begin
            step(1'b1, 2'b01);
            chk(i < PERS ? "R11" : "R9", i < PERS ? 3'b011 : 3'b101);
        end

        // R10: disable from WAIT, SOFT and RUN clears counts
        en = 1'b0;
        step(1'b0, '0);
        chk("R10", 3'b100);
        en = 1'b1;
        step(1'b0, '0);
        chk("R10", 3'b000);
        step(1'b0, 2'b11);
        chk("R3", 3'b101);
        wait_phase(1, "R6");
        en = 1'b0;
        step(1'b0, '0);
        chk("R10", 3'b100);
        en = 1'b1;
        step(1'b0, '0);
        chk("R2", 3'b000);
        for (int i = 1; i <= PERS - 1; i++) begin
            step(1'b1, 2'b10);
            chk("R10", 3'b000);
        end
        en = 1'b0;
        step(1'b0, '0);
        chk("R10", 3'b100);
        en = 1'b1;
        step(1'b0, '0);
        for (int i = 1; i <= PERS; i++) begin
            step(1'b1, 2'b10);
            chk("R10", i < PERS ? 3'b000 : 3'b101);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule